// File: doc/BRIEF.md
# Tightly Coupled Memory Request Interface

This block drives the request side of a single-ported on-chip data SRAM that a processor load/store unit reaches without a cache or bus between them. The core presents a request strobe, a word address, a direction, write data and a wait indication every cycle. The block turns these into a registered memory address, a chip select, a direction bit, an idle flag and a sequential-access flag. Read data returned by the SRAM is captured and handed back to the core with a one-cycle valid pulse.

A second agent, such as a DMA engine, can take over the address path. While its enable is high, its address goes to the memory in place of the core address. Its chip select is ORed with the chip select of the core request. A memory-enable input shuts off every core-originated access without affecting the DMA path.

All memory-side outputs are registered, so every output reflects the inputs of the previous clock cycle.

Top module: `tcm_req_if`

## Requirements
- R1: After synchronous reset, mem_cs=0, mem_idle=1, mem_wr=0, mem_seq=0, mem_addr=0 and core_rvalid=0.
- R2: A core request is granted in a cycle when core_req=1, core_wait=0 and mem_en=1. One cycle after a grant, mem_cs=1, mem_idle=0, mem_addr is the core address unless DMA is enabled, and mem_wr reflects core_wr (0 = read, 1 = write).
- R3: One cycle after a cycle with no grant and no DMA enable, mem_cs=0, mem_idle=1 and mem_wr=0, and mem_addr keeps its previous value.
- R4: One cycle after a cycle with dma_en=1, mem_addr equals the dma_addr of that cycle, whatever the core presents.
- R5: With dma_en=1, mem_cs is the OR of dma_cs and the core grant, while mem_idle still reflects only the core grant.
- R6: While mem_en=0, core requests produce no chip select and mem_idle stays 1, but DMA chip selects and addresses still pass.
- R7: One cycle after a grant, mem_seq=1 exactly when the granted address equals the previously granted address plus one, modulo 2^AW (so address 0 after the top address counts as sequential). After a cycle with neither a grant nor a wait, mem_seq=0.
- R8: One cycle after any cycle with core_wait=1, mem_seq=1. A waited cycle does not replace the stored previous address.
- R9: The stored previous address is cleared on reset, and the first grant after reset has mem_seq=0 even when its address is 1.
- R10: The data cycle of a read is the cycle after mem_cs shows it. mem_rdata is taken in that cycle only if core_wait=0; otherwise the data cycle repeats. One cycle after the capture, core_rvalid pulses high for one cycle and core_rdata holds the captured word.
- R11: One cycle after a granted write, mem_wdata holds the core_wdata of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_en | input | 1 | Enables core-originated accesses |
| core_req | input | 1 | Core request strobe |
| core_wr | input | 1 | Core direction, 1 = write |
| core_wait | input | 1 | Core wait indication |
| core_addr | input | AW | Core word address |
| core_wdata | input | DW | Core write data |
| core_rdata | output | DW | Captured read data |
| core_rvalid | output | 1 | One-cycle pulse marking new read data |
| dma_en | input | 1 | DMA takes the address path |
| dma_cs | input | 1 | DMA chip select |
| dma_addr | input | AW | DMA word address |
| mem_addr | output | AW | Memory word address |
| mem_cs | output | 1 | Chip select, access in the following cycle |
| mem_wr | output | 1 | Direction, 0 = read, 1 = write |
| mem_idle | output | 1 | 1 when no core access takes place |
| mem_seq | output | 1 | Sequential-address flag |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |

## Verification
The bench builds the block with its defaults, AW=18 and DW=32. At this width the all-ones address 18'h3FFFF is reachable, so the modulo wrap of the sequential comparison can be exercised directly. The 32-bit data path lets distinct read and write words show that the read capture and the write register are aligned to the right cycle. Address 1 right after reset falls within the same reach and shows that the cleared previous-address register is not taken as a valid predecessor.

// File: rtl/tcm_req_pkg.sv
package tcm_req_pkg;
  localparam int unsigned TCM_AW_DEF = 18;
  localparam int unsigned TCM_DW_DEF = 32;

  // successor of a word address, wrapping at the address width
  function automatic logic [TCM_AW_DEF-1:0] word_succ(input logic [TCM_AW_DEF-1:0] a);
    return a + 1'b1;
  endfunction
endpackage

// File: rtl/tcm_addr_path.sv
module tcm_addr_path #(
  parameter int unsigned AW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          core_grant,
  input  logic          core_wr,
  input  logic [AW-1:0] core_addr,
  input  logic          dma_en,
  input  logic          dma_cs,
  input  logic [AW-1:0] dma_addr,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs,
  output logic          mem_wr,
  output logic          mem_idle
);
  logic [AW-1:0] addr_q;
  logic          cs_q, wr_q, idle_q;
  logic          dma_sel;

  assign dma_sel = dma_en & dma_cs;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cs_q   <= 1'b0;
      wr_q   <= 1'b0;
      idle_q <= 1'b1;
    end else begin
      if (dma_en)
        addr_q <= dma_addr;
      else if (core_grant)
        addr_q <= core_addr;
      cs_q   <= core_grant | dma_sel;
      wr_q   <= core_grant & core_wr;
      idle_q <= ~core_grant;
    end
  end

  assign mem_addr = addr_q;
  assign mem_cs   = cs_q;
  assign mem_wr   = wr_q;
  assign mem_idle = idle_q;
endmodule

// File: rtl/tcm_seq_track.sv
module tcm_seq_track #(
  parameter int unsigned AW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          core_grant,
  input  logic          core_wait,
  input  logic [AW-1:0] core_addr,
  output logic          mem_seq
);
  logic [AW-1:0] last_addr;
  logic          last_ok;
  logic          seq_q;
  logic [AW-1:0] succ;
  logic          match;

  assign succ  = last_addr + {{(AW-1){1'b0}}, 1'b1};
  assign match = last_ok && (core_addr == succ);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_addr <= '0;
      last_ok   <= 1'b0;
      seq_q     <= 1'b0;
    end else begin
      if (core_grant) begin
        last_addr <= core_addr;
        last_ok   <= 1'b1;
      end
      if (core_wait)
        seq_q <= 1'b1;
      else if (core_grant)
        seq_q <= match;
      else
        seq_q <= 1'b0;
    end
  end

  assign mem_seq = seq_q;
endmodule

// File: rtl/tcm_rd_return.sv
module tcm_rd_return #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_grant,
  input  logic          core_wait,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] core_rdata,
  output logic          core_rvalid
);
  logic          rd_req_q;
  logic          data_cyc_q;
  logic          take;
  logic [DW-1:0] rdata_q;
  logic          rvalid_q;

  assign take = data_cyc_q & ~core_wait;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req_q   <= 1'b0;
      data_cyc_q <= 1'b0;
      rdata_q    <= '0;
      rvalid_q   <= 1'b0;
    end else begin
      rd_req_q   <= rd_grant;
      data_cyc_q <= rd_req_q | (data_cyc_q & core_wait);
      rvalid_q   <= take;
      if (take)
        rdata_q <= mem_rdata;
    end
  end

  assign core_rdata  = rdata_q;
  assign core_rvalid = rvalid_q;
endmodule

// File: rtl/tcm_req_if.sv
module tcm_req_if
  import tcm_req_pkg::*;
#(
  parameter int unsigned AW = TCM_AW_DEF,
  parameter int unsigned DW = TCM_DW_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mem_en,
  input  logic          core_req,
  input  logic          core_wr,
  input  logic          core_wait,
  input  logic [AW-1:0] core_addr,
  input  logic [DW-1:0] core_wdata,
  output logic [DW-1:0] core_rdata,
  output logic          core_rvalid,
  input  logic          dma_en,
  input  logic          dma_cs,
  input  logic [AW-1:0] dma_addr,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs,
  output logic          mem_wr,
  output logic          mem_idle,
  output logic          mem_seq,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  logic          grant;
  logic          rd_grant;
  logic [DW-1:0] wdata_q;

  assign grant    = core_req & ~core_wait & mem_en;
  assign rd_grant = grant & ~core_wr;

  tcm_addr_path #(.AW(AW)) u_addr (
    .clk(clk), .rst(rst),
    .core_grant(grant), .core_wr(core_wr), .core_addr(core_addr),
    .dma_en(dma_en), .dma_cs(dma_cs), .dma_addr(dma_addr),
    .mem_addr(mem_addr), .mem_cs(mem_cs), .mem_wr(mem_wr), .mem_idle(mem_idle)
  );

  tcm_seq_track #(.AW(AW)) u_seq (
    .clk(clk), .rst(rst),
    .core_grant(grant), .core_wait(core_wait), .core_addr(core_addr),
    .mem_seq(mem_seq)
  );

  tcm_rd_return #(.DW(DW)) u_rd (
    .clk(clk), .rst(rst),
    .rd_grant(rd_grant), .core_wait(core_wait), .mem_rdata(mem_rdata),
    .core_rdata(core_rdata), .core_rvalid(core_rvalid)
  );

  always_ff @(posedge clk) begin
    if (rst)
      wdata_q <= '0;
    else if (grant & core_wr)
      wdata_q <= core_wdata;
  end

  assign mem_wdata = wdata_q;
endmodule

// File: rtl/tcm_req_if_chk.sv
module tcm_req_if_chk #(
  parameter int unsigned AW = 18,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_en,
  input logic          core_req,
  input logic          core_wr,
  input logic          core_wait,
  input logic [AW-1:0] core_addr,
  input logic          core_rvalid,
  input logic          dma_en,
  input logic          dma_cs,
  input logic [AW-1:0] dma_addr,
  input logic [AW-1:0] mem_addr,
  input logic          mem_cs,
  input logic          mem_wr,
  input logic          mem_idle,
  input logic          mem_seq
);
  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (mem_idle && !mem_cs && !core_rvalid));
  p_grant_cs_r2: assert property (@(posedge clk) disable iff (rst)
    (core_req && !core_wait && mem_en) |=> (mem_cs && !mem_idle && mem_wr == $past(core_wr)));
  p_no_access_r3: assert property (@(posedge clk) disable iff (rst)
    (!dma_en && !(core_req && !core_wait && mem_en)) |=> (!mem_cs && mem_idle && $stable(mem_addr)));
  p_dma_addr_r4: assert property (@(posedge clk) disable iff (rst)
    dma_en |=> (mem_addr == $past(dma_addr)));
  p_dma_cs_r5: assert property (@(posedge clk) disable iff (rst)
    (dma_en && dma_cs) |=> mem_cs);
  p_mem_off_r6: assert property (@(posedge clk) disable iff (rst)
    !mem_en |=> mem_idle);
  p_gap_seq_r7: assert property (@(posedge clk) disable iff (rst)
    (!core_wait && !(core_req && mem_en)) |=> !mem_seq);
  p_wait_seq_r8: assert property (@(posedge clk) disable iff (rst)
    core_wait |=> mem_seq);
  p_idle_cs_r5: assert property (@(posedge clk) disable iff (rst)
    !mem_idle |-> mem_cs);
  p_rvalid_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    core_rvalid |=> !core_rvalid || $past(core_wait) == 1'b0);
endmodule

bind tcm_req_if tcm_req_if_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .mem_en(mem_en), .core_req(core_req), .core_wr(core_wr),
  .core_wait(core_wait), .core_addr(core_addr), .core_rvalid(core_rvalid),
  .dma_en(dma_en), .dma_cs(dma_cs), .dma_addr(dma_addr), .mem_addr(mem_addr),
  .mem_cs(mem_cs), .mem_wr(mem_wr), .mem_idle(mem_idle), .mem_seq(mem_seq)
);

// File: tb/tcm_req_if_bench.sv
module tcm_req_if_bench;
  localparam int AW = 18;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mem_en = 1'b1, core_req = 1'b0, core_wr = 1'b0, core_wait = 1'b0;
  logic [AW-1:0] core_addr = '0;
  logic [DW-1:0] core_wdata = '0;
  logic [DW-1:0] core_rdata;
  logic          core_rvalid;
  logic          dma_en = 1'b0, dma_cs = 1'b0;
  logic [AW-1:0] dma_addr = '0;
  logic [AW-1:0] mem_addr;
  logic          mem_cs, mem_wr, mem_idle, mem_seq;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tcm_req_if #(.AW(AW), .DW(DW)) u_tcm_req_if (
    .clk(clk), .rst(rst), .mem_en(mem_en), .core_req(core_req), .core_wr(core_wr),
    .core_wait(core_wait), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_rdata(core_rdata), .core_rvalid(core_rvalid), .dma_en(dma_en),
    .dma_cs(dma_cs), .dma_addr(dma_addr), .mem_addr(mem_addr), .mem_cs(mem_cs),
    .mem_wr(mem_wr), .mem_idle(mem_idle), .mem_seq(mem_seq), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  typedef struct packed {
    logic          req, wr, wt, en, de, dc;
    logic [AW-1:0] a, da;
    logic          xcs, xidle, xwr, xseq;
    logic [AW-1:0] xa;
    logic [7:0]    tag;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 18'h10,    18'h0,   1'b1,1'b0,1'b0,1'b0, 18'h10,    8'd2},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 18'h11,    18'h0,   1'b1,1'b0,1'b0,1'b1, 18'h11,    8'd7},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 18'h12,    18'h0,   1'b1,1'b0,1'b1,1'b1, 18'h12,    8'd2},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 18'h20,    18'h0,   1'b1,1'b0,1'b1,1'b0, 18'h20,    8'd7},
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0, 18'h21,    18'h0,   1'b0,1'b1,1'b0,1'b1, 18'h20,    8'd8},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 18'h21,    18'h0,   1'b1,1'b0,1'b0,1'b1, 18'h21,    8'd8},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 18'h55,    18'h0,   1'b0,1'b1,1'b0,1'b0, 18'h21,    8'd3},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 18'h22,    18'h0,   1'b1,1'b0,1'b0,1'b1, 18'h22,    8'd7},
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1, 18'h0,     18'h3ABCD,1'b1,1'b1,1'b0,1'b0, 18'h3ABCD, 8'd5},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b0, 18'h23,    18'h100, 1'b1,1'b0,1'b0,1'b1, 18'h100,   8'd4},
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 18'h0,     18'h200, 1'b0,1'b1,1'b0,1'b0, 18'h200,   8'd4},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 18'h24,    18'h0,   1'b0,1'b1,1'b0,1'b0, 18'h200,   8'd6},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 18'h0,     18'h300, 1'b1,1'b1,1'b0,1'b0, 18'h300,   8'd6},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 18'h24,    18'h0,   1'b1,1'b0,1'b1,1'b1, 18'h24,    8'd7},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 18'h3FFFF, 18'h0,   1'b1,1'b0,1'b0,1'b0, 18'h3FFFF, 8'd7},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 18'h0,     18'h0,   1'b1,1'b0,1'b0,1'b1, 18'h0,     8'd7}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    core_req = 1'b0; core_wr = 1'b0; core_wait = 1'b0; mem_en = 1'b1;
    dma_en = 1'b0; dma_cs = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 cs", {31'd0, mem_cs}, 32'd0);
    check("R1 idle", {31'd0, mem_idle}, 32'd1);
    check("R1 wr", {31'd0, mem_wr}, 32'd0);
    check("R1 seq", {31'd0, mem_seq}, 32'd0);
    check("R1 addr", {14'd0, mem_addr}, 32'd0);
    check("R1 rvalid", {31'd0, core_rvalid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      core_req = VECS[i].req; core_wr = VECS[i].wr; core_wait = VECS[i].wt;
      mem_en = VECS[i].en; dma_en = VECS[i].de; dma_cs = VECS[i].dc;
      core_addr = VECS[i].a; dma_addr = VECS[i].da;
      @(negedge clk);
      check($sformatf("R%0d v%0d cs", VECS[i].tag, i), {31'd0, mem_cs}, {31'd0, VECS[i].xcs});
      check($sformatf("R%0d v%0d idle", VECS[i].tag, i), {31'd0, mem_idle}, {31'd0, VECS[i].xidle});
      check($sformatf("R%0d v%0d wr", VECS[i].tag, i), {31'd0, mem_wr}, {31'd0, VECS[i].xwr});
      check($sformatf("R%0d v%0d seq", VECS[i].tag, i), {31'd0, mem_seq}, {31'd0, VECS[i].xseq});
      check($sformatf("R%0d v%0d addr", VECS[i].tag, i), {14'd0, mem_addr}, {14'd0, VECS[i].xa});
    end

    // R9: first grant after reset at address 1 is not sequential
    idle_inputs();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    core_req = 1'b1; core_addr = 18'h1;
    @(negedge clk);
    check("R9 seq after reset", {31'd0, mem_seq}, 32'd0);
    check("R9 addr", {14'd0, mem_addr}, 32'h1);

    // R11: write data registered with the grant
    core_wr = 1'b1; core_addr = 18'h2; core_wdata = 32'hDEADBEEF;
    @(negedge clk);
    check("R11 wdata", mem_wdata, 32'hDEADBEEF);
    check("R7 seq 1->2", {31'd0, mem_seq}, 32'd1);

    // R10: unwaited read return
    core_wr = 1'b0; core_addr = 18'h3;
    @(negedge clk);                      // mem_cs shows the read
    idle_inputs();
    check("R10 cs shown", {31'd0, mem_cs}, 32'd1);
    @(negedge clk);                      // data cycle now
    mem_rdata = 32'hCAFE0001;
    check("R10 no early rvalid", {31'd0, core_rvalid}, 32'd0);
    @(negedge clk);
    mem_rdata = 32'h0;
    check("R10 rvalid", {31'd0, core_rvalid}, 32'd1);
    check("R10 rdata", core_rdata, 32'hCAFE0001);
    @(negedge clk);
    check("R10 rvalid pulse ends", {31'd0, core_rvalid}, 32'd0);
    check("R10 rdata held", core_rdata, 32'hCAFE0001);

    // R10: waited data cycle repeats
    core_req = 1'b1; core_addr = 18'h40;
    @(negedge clk);
    idle_inputs();
    @(negedge clk);                      // data cycle, but waited
    core_wait = 1'b1; mem_rdata = 32'h11111111;
    @(negedge clk);
    check("R10 waited no rvalid", {31'd0, core_rvalid}, 32'd0);
    check("R8 wait seq", {31'd0, mem_seq}, 32'd1);
    core_wait = 1'b0; mem_rdata = 32'h22222222;
    @(negedge clk);
    check("R10 waited rvalid", {31'd0, core_rvalid}, 32'd1);
    check("R10 waited rdata", core_rdata, 32'h22222222);

    idle_inputs();
    @(negedge clk);
    finish_run();
  end
endmodule